// File: doc/BRIEF.md
# Watchdog timer with change protection

This block is a watchdog timer controlled through one byte-wide control and status register. A 4-bit prescale field selects the timeout period. The period is a base period in clock cycles, shifted left by the prescale value, and the shift saturates at 9. When the period runs out, the block raises an interrupt, pulses a system-reset request, or does both in escalation. A restart pulse from the CPU starts the count again.

The reset-enable bit and the prescale bits are protected against stray writes. Software first writes a request pattern, which opens a short change window. Only a write that lands inside that window can alter these protected bits. An external reset-cause input pins the reset enable on. An acknowledge input marks the CPU taking the watchdog interrupt vector. The acknowledge disarms the interrupt, so the next timeout resets the system unless software re-arms it.

Top module: `wdog_guard`

## Requirements
- R1: After reset, the register reads 0x00 and both `irq_o` and `sys_rst_o` are low.
- R2: The register bits are: bit7 interrupt flag, bit6 interrupt enable, bit5 prescale[3], bit4 change request on write and window-open on read, bit3 reset enable, bits2:0 prescale[2:0]. Every write loads the interrupt enable from bit6.
- R3: Writing 1 to bit7 clears the interrupt flag. Writing 0 to bit7 leaves it unchanged. No write can set it.
- R4: A write that arrives while the change window is closed leaves the reset enable and all four prescale bits unchanged.
- R5: A write with bit4=1 and bit3=1 opens the change window. Writes in each of the next 4 cycles update the protected bits, and a write in the 5th cycle does not. Bit4 reads 1 while the window is open. A write with bit4=1 and bit3=0 does not open the window.
- R6: The timeout period is BASE_CYCLES << min(prescale, 9) cycles after the last reload. With interrupt enable and reset enable both 0, no timeout occurs.
- R7: A restart pulse, any register write, and every timeout each reload the counter for the selected period. A reload in a cycle suppresses the timeout in that cycle.
- R8: A timeout with interrupt enable 1 sets the flag. `irq_o` is high while both the flag and the interrupt enable are 1.
- R9: A timeout with reset enable 1 and interrupt enable 0 drives `sys_rst_o` high for exactly one cycle.
- R10: `irq_ack_i` clears both the flag and the interrupt enable. A timeout with reset enable 1 while the flag is still set also requests a reset.
- R11: While `rst_flag_i` is 1, the reset enable reads 1 from the next cycle on, and no write can clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| kick_i | input | 1 | Restart pulse for the timeout counter |
| rst_flag_i | input | 1 | External reset-cause flag; forces reset enable |
| irq_ack_i | input | 1 | CPU took the watchdog interrupt |
| irq_o | output | 1 | Interrupt request (level) |
| sys_rst_o | output | 1 | System-reset request (one-cycle pulse) |

## Verification
Register semantics are tried with a write sequence that walks the change window from its opening write through each of its four accepting cycles to the first rejected cycle. This separates an off-by-one window length from correct expiry, and an opening pattern without bit3 from a real opening. Timeout behaviour is tried under prescale 0, prescale 2 and a saturated prescale of 15, which tells a correct shift from a missing clamp. A restart pulse just before expiry shows that the counter reloads instead of firing. Two escalation runs, one with an acknowledge and one without, show that both paths reach the reset request on the second timeout and not on the first.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned BIT_FLAG   = 7;
  localparam int unsigned BIT_IEN    = 6;
  localparam int unsigned BIT_PRE3   = 5;
  localparam int unsigned BIT_CHG    = 4;
  localparam int unsigned BIT_REN    = 3;
  localparam int unsigned WIN_CYCLES = 4;
  localparam int unsigned PRE_W      = 4;
  localparam int unsigned PRE_SAT    = 9;

  typedef struct packed {
    logic             flag;
    logic             ien;
    logic             ren;
    logic [PRE_W-1:0] pre;
  } csr_t;
endpackage

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int unsigned WIN = wdog_pkg::WIN_CYCLES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_i,
  output logic open_o
);
  localparam int unsigned CW = $clog2(WIN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (open_i)         cnt_q <= CW'(WIN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign open_o = (cnt_q != '0);
endmodule

// File: rtl/wdog_csr.sv
module wdog_csr
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       win_open_i,
  input  logic       rst_flag_i,
  input  logic       ack_i,
  input  logic       expire_i,
  output csr_t       csr_q_o,
  output csr_t       csr_d_o
);
  csr_t q, d;

  always_comb begin
    d = q;
    if (we_i) begin
      d.ien = wdata_i[BIT_IEN];
      if (wdata_i[BIT_FLAG]) d.flag = 1'b0;
      if (win_open_i) begin
        d.ren = wdata_i[BIT_REN];
        d.pre = {wdata_i[BIT_PRE3], wdata_i[2:0]};
      end
    end
    // acknowledge disarms; a coincident timeout still sets the flag
    if (ack_i) begin
      d.flag = 1'b0;
      d.ien  = 1'b0;
    end
    if (expire_i && q.ien) d.flag = 1'b1;
    if (rst_flag_i)        d.ren  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign csr_q_o = q;
  assign csr_d_o = d;
endmodule

// File: rtl/wdog_period.sv
module wdog_period #(
  parameter int unsigned BASE    = 3000,
  parameter int unsigned PRE_SAT = wdog_pkg::PRE_SAT,
  parameter int unsigned PRE_W   = wdog_pkg::PRE_W,
  parameter int unsigned CNT_W   = $clog2(BASE << PRE_SAT)
) (
  input  logic [PRE_W-1:0] pre_i,
  output logic [CNT_W-1:0] period_m1_o
);
  localparam int unsigned N = 1 << PRE_W;

  logic [CNT_W-1:0] tab [N];

  for (genvar i = 0; i < N; i++) begin : g_tab
    localparam int unsigned SH = (i > PRE_SAT) ? PRE_SAT : i;
    assign tab[i] = CNT_W'((BASE << SH) - 1);
  end

  assign period_m1_o = tab[pre_i];
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == '0) && !reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= CNT_W'(RST_VAL);
    else if (!run_i || reload_i || cnt_q == '0) cnt_q <= load_i;
    else                                        cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_CYCLES = 3000  // >= 2, BASE_CYCLES << PRE_SAT < 2**32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       kick_i,
  input  logic       rst_flag_i,
  input  logic       irq_ack_i,
  output logic       irq_o,
  output logic       sys_rst_o
);
  localparam int unsigned CNT_W = $clog2(BASE_CYCLES << PRE_SAT);

  csr_t             csr_q, csr_d;
  logic             win_open, win_req, expire, run, reload, rst_req_q;
  logic [CNT_W-1:0] load_val;

  assign win_req = reg_we_i && reg_wdata_i[BIT_CHG] && reg_wdata_i[BIT_REN];

  wdog_window #(.WIN(WIN_CYCLES)) i_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (win_req),
    .open_o (win_open)
  );

  wdog_csr i_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .win_open_i (win_open),
    .rst_flag_i (rst_flag_i),
    .ack_i      (irq_ack_i),
    .expire_i   (expire),
    .csr_q_o    (csr_q),
    .csr_d_o    (csr_d)
  );

  // reload value follows the next-state prescale so a write takes effect at once
  wdog_period #(
    .BASE    (BASE_CYCLES),
    .PRE_SAT (PRE_SAT),
    .PRE_W   (PRE_W),
    .CNT_W   (CNT_W)
  ) i_period (
    .pre_i       (csr_d.pre),
    .period_m1_o (load_val)
  );

  assign run    = csr_q.ien || csr_q.ren;
  assign reload = kick_i || reg_we_i;

  wdog_timer #(.CNT_W(CNT_W), .RST_VAL(BASE_CYCLES - 1)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .reload_i (reload),
    .load_i   (load_val),
    .expire_o (expire)
  );

  // reset when interrupt is disarmed or its previous timeout went unserviced
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= expire && csr_q.ren && (!csr_q.ien || csr_q.flag);
  end

  assign sys_rst_o   = rst_req_q;
  assign irq_o       = csr_q.flag && csr_q.ien;
  assign reg_rdata_o = {csr_q.flag, csr_q.ien, csr_q.pre[3], win_open,
                        csr_q.ren, csr_q.pre[2:0]};
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       rst_flag_i,
  input logic       irq_ack_i,
  input logic       sys_rst_o
);
  logic [2:0] win_ref;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          win_ref <= 3'd0;
    else if (reg_we_i && reg_wdata_i[4] && reg_wdata_i[3]) win_ref <= 3'd4;
    else if (win_ref != 3'd0)                             win_ref <= win_ref - 3'd1;
  end

  a_r3_flag_not_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[7]) |-> !$past(reg_we_i));

  a_r4_pre_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_rdata_o[4]) |=> $stable({reg_rdata_o[5], reg_rdata_o[2:0]}));

  a_r5_window_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[4] == (win_ref != 3'd0));

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o);

  a_r10_ack_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |=> !reg_rdata_o[6]);

  a_r11_cause_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_flag_i |=> reg_rdata_o[3]);
endmodule

bind wdog_guard wdog_guard_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .rst_flag_i  (rst_flag_i),
  .irq_ack_i   (irq_ack_i),
  .sys_rst_o   (sys_rst_o)
);

// File: tb/test_wdog_guard.sv
`timescale 1ns/1ps
module test_wdog_guard;
  localparam int unsigned BASE = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       kick_i = 1'b0;
  logic       rst_flag_i = 1'b0;
  logic       irq_ack_i = 1'b0;
  logic       irq_o;
  logic       sys_rst_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  wdog_guard #(.BASE_CYCLES(BASE)) i_wdog_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .kick_i      (kick_i),
    .rst_flag_i  (rst_flag_i),
    .irq_ack_i   (irq_ack_i),
    .irq_o       (irq_o),
    .sys_rst_o   (sys_rst_o)
  );

  // {write data, expected read-back}; consecutive cycles from a fresh reset
  localparam logic [15:0] REG_VEC [0:11] = '{
    16'h4040,  // R2 interrupt enable writable
    16'h0F00,  // R4 protected bits locked
    16'h1000,  // R5 request without bit3 does not open
    16'h1810,  // R5 opening write
    16'h0A1A,  // R4 R5 accepted, cycle 1
    16'h2131,  // R5 accepted, cycle 2
    16'h0010,  // R5 accepted, cycle 3
    16'h0808,  // R5 accepted, cycle 4, window closes
    16'h0008,  // R5 cycle 5 rejected
    16'h1818,  // R5 reopen, reset enable kept
    16'h0010,  // R5 clear reset enable in window
    16'h8010   // R3 software cannot set flag
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; reg_we_i = 1'b0; kick_i = 1'b0; rst_flag_i = 1'b0; irq_ack_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] v);
    reg_we_i = 1'b1; reg_wdata_i = v;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic pulse_kick();
    kick_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    kick_i = 1'b0;
  endtask

  task automatic pulse_ack();
    irq_ack_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    irq_ack_i = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 rdata", 32'(reg_rdata_o), 32'h00);
    check("R1 irq", 32'(irq_o), 0);
    check("R1 sys_rst", 32'(sys_rst_o), 0);

    for (int i = 0; i < 12; i++) begin
      wr(REG_VEC[i][15:8]);
      check($sformatf("R2 R3 R4 R5 vector %0d", i), 32'(reg_rdata_o), 32'(REG_VEC[i][7:0]));
    end

    // R6 stopped when both enables are clear
    do_reset();
    wait_n(40);
    check("R6 stopped irq", 32'(irq_o), 0);
    check("R6 stopped rst", 32'(sys_rst_o), 0);

    // R8 interrupt mode, prescale 0
    do_reset();
    wr(8'h40);
    wait_n(BASE - 1);
    check("R8 before timeout", 32'(irq_o), 0);
    wait_n(1);
    check("R8 irq at timeout", 32'(irq_o), 1);
    check("R8 flag readback", 32'(reg_rdata_o), 32'hC0);
    wr(8'hC0);
    check("R3 flag cleared by 1", 32'(reg_rdata_o), 32'h40);
    check("R3 irq low", 32'(irq_o), 0);

    // R6 prescale 2
    do_reset();
    wr(8'h18);
    wr(8'h42);
    wait_n((BASE << 2) - 1);
    check("R6 pre2 early", 32'(irq_o), 0);
    wait_n(1);
    check("R6 pre2 timeout", 32'(irq_o), 1);

    // R6 prescale saturates at 9
    do_reset();
    wr(8'h18);
    wr(8'h67);
    wait_n((BASE << 9) - 1);
    check("R6 sat early", 32'(irq_o), 0);
    wait_n(1);
    check("R6 sat timeout", 32'(irq_o), 1);

    // R7 restart pulse reloads
    do_reset();
    wr(8'h40);
    wait_n(2);
    pulse_kick();
    wait_n(1);
    check("R7 no timeout at old expiry", 32'(irq_o), 0);
    wait_n(2);
    check("R7 before reloaded expiry", 32'(irq_o), 0);
    wait_n(1);
    check("R7 reloaded expiry", 32'(irq_o), 1);

    // R9 reset mode
    do_reset();
    wr(8'h18);
    wr(8'h08);
    wait_n(BASE - 1);
    check("R9 before timeout", 32'(sys_rst_o), 0);
    wait_n(1);
    check("R9 reset pulse", 32'(sys_rst_o), 1);
    check("R9 no irq", 32'(irq_o), 0);
    wait_n(1);
    check("R9 pulse one cycle", 32'(sys_rst_o), 0);

    // R10 combined mode with acknowledge
    do_reset();
    wr(8'h18);
    wr(8'h48);
    wait_n(BASE);
    check("R10 first timeout irq", 32'(irq_o), 1);
    check("R10 first timeout no rst", 32'(sys_rst_o), 0);
    pulse_ack();
    check("R10 ack clears flag and enable", 32'(reg_rdata_o), 32'h08);
    check("R10 irq low after ack", 32'(irq_o), 0);
    wait_n(2);
    check("R10 before second timeout", 32'(sys_rst_o), 0);
    wait_n(1);
    check("R10 second timeout resets", 32'(sys_rst_o), 1);

    // R10 combined mode, interrupt never serviced
    do_reset();
    wr(8'h18);
    wr(8'h48);
    wait_n(BASE);
    check("R10 unserviced first irq", 32'(irq_o), 1);
    check("R10 unserviced first no rst", 32'(sys_rst_o), 0);
    wait_n(BASE - 1);
    check("R10 unserviced before second", 32'(sys_rst_o), 0);
    wait_n(1);
    check("R10 unserviced escalates", 32'(sys_rst_o), 1);

    // R11 external reset cause pins reset enable
    do_reset();
    rst_flag_i = 1'b1;
    wait_n(1);
    check("R11 forced on", 32'(reg_rdata_o[3]), 1);
    wr(8'h18);
    wr(8'h00);
    check("R11 cannot clear", 32'(reg_rdata_o[3]), 1);
    rst_flag_i = 1'b0;
    wr(8'h18);
    wr(8'h00);
    check("R11 clears after release", 32'(reg_rdata_o[3]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule